// File: doc/BRIEF.md
# Cross-Domain Parameter Register Bank

This block carries parameter updates from a slow clock domain into a bank of registers in a fast clock domain. A 64-bit command word arrives on a valid/ready stream clocked by the slow clock. The upper byte of the word names a destination module, the next byte is a command code and the low bits hold the payload. Words addressed to this instance are written into one gray-pointer dual-clock FIFO. All other words are consumed and dropped. Every parameter bound for the fast domain shares this single crossing, so there is no separate synchronizer per register.

On the fast side the block pops one entry per fast cycle while the FIFO holds data. It decodes the command and writes the selected 14-bit register in a bank of 32. Each write raises a single-cycle strobe that carries the register index. The register outputs drive fast-domain logic directly.

Back-pressure: `s_ready` is high whenever the FIFO has space. A word transfers on a rising `s_clk` edge where both `s_valid` and `s_ready` are high. While `s_valid` is high and `s_ready` is low, the source must hold `s_data` unchanged. Words addressed to other modules obey the same handshake and are then discarded.

Top module: `param_xdomain_bank`

## Requirements
- R1: Field positions: bits 63:56 of `s_data` give the module number, bits 55:48 give the command code and bits 13:0 give the parameter value. Payload bits 47:14 have no effect.
- R2: A word whose module number differs from `MODULE_ID` is consumed by the handshake and then dropped. It changes no register and raises no strobe.
- R3: `s_ready` is low while the FIFO holds 16 entries, and no accepted word is lost.
- R4: A word transfers only on a slow edge where `s_valid` and `s_ready` are both high. A stalled source keeps `s_data` stable.
- R5: Updates reach the register bank in the same order the words were accepted.
- R6: Command codes 0 to 31 write the value into the register with that index. No other register changes.
- R7: Command codes 32 to 255 change no register and raise no strobe. They set `cmd_err`, which stays high until the fast-domain reset.
- R8: Each register write produces exactly one `upd_valid` cycle with `upd_idx` equal to the index. The new value appears on `param_o` in that same cycle, and registers change only in strobe cycles.
- R9: While both resets are applied, all registers read zero, `upd_valid` and `cmd_err` are low, the FIFO is empty and `s_ready` is high once the slow reset is released. Register `i` occupies `param_o[14*i+13:14*i]`.
- R10: FIFO pointers cross domains in gray code, changing by at most one bit per edge. Data passes intact across pointer wrap-around.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| s_clk | input | 1 | Slow source clock |
| s_rst_n | input | 1 | Slow-domain active-low asynchronous reset |
| s_valid | input | 1 | Source word valid |
| s_ready | output | 1 | Block can take a word (FIFO not full) |
| s_data | input | 64 | Command word: module, command, payload |
| f_clk | input | 1 | Fast destination clock |
| f_rst_n | input | 1 | Fast-domain active-low asynchronous reset |
| param_o | output | NPARAM*PW (448) | All parameter registers, index 0 in the low bits |
| upd_valid | output | 1 | One-cycle strobe on each register write |
| upd_idx | output | $clog2(NPARAM) (5) | Index of the register just written |
| cmd_err | output | 1 | Sticky flag: an out-of-range command was popped |

## Verification
The assertions assume a source that holds a stalled word unchanged. They also assume that both domain resets are applied together, so the two FIFO pointers restart from the same point. The bench's send task keeps `s_valid` and `s_data` fixed until it sees a handshake. Reset is always applied to both domains at once. Back-pressure is reached by stopping the fast clock while the source fills the FIFO. This stays within the stated assumptions, because a stopped reader only delays the read pointer.

// File: rtl/pdist_pkg.sv
`timescale 1ns/1ps
package pdist_pkg;
  localparam int WORD_W = 64;
  localparam int MOD_W  = 8;
  localparam int CMD_W  = 8;
  localparam int PAY_W  = WORD_W - MOD_W - CMD_W;

  typedef struct packed {
    logic [MOD_W-1:0] module_id;
    logic [CMD_W-1:0] cmd;
    logic [PAY_W-1:0] payload;
  } pdist_word_t;
endpackage

// File: rtl/pdist_sync.sv
`timescale 1ns/1ps
module pdist_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/pdist_afifo.sv
`timescale 1ns/1ps
module pdist_afifo #(
  parameter int DW = 22,
  parameter int AW = 4
) (
  input  logic          wclk,
  input  logic          wrst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output logic          full,
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic          rd_en,
  output logic [DW-1:0] rdata,
  output logic          empty
);
  localparam int DEPTH = 1 << AW;
  localparam int PTR_W = AW + 1;

  logic [DW-1:0]    mem [DEPTH];
  logic [PTR_W-1:0] wbin, wgray, rbin, rgray;
  logic [PTR_W-1:0] rgray_at_w, wgray_at_r;
  logic [PTR_W-1:0] wbin_nx, rbin_nx;
  logic             wpush, rpop;

  function automatic logic [PTR_W-1:0] to_gray(input logic [PTR_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PTR_W-1:0] to_bin(input logic [PTR_W-1:0] g);
    logic [PTR_W-1:0] b;
    b[PTR_W-1] = g[PTR_W-1];
    for (int i = PTR_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  assign wpush   = wr_en && !full;
  assign rpop    = rd_en && !empty;
  assign wbin_nx = wbin + PTR_W'(wpush);
  assign rbin_nx = rbin + PTR_W'(rpop);

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin  <= '0;
      wgray <= '0;
    end else begin
      wbin  <= wbin_nx;
      wgray <= to_gray(wbin_nx);
    end
  end

  always_ff @(posedge wclk) begin
    if (wpush) mem[wbin[AW-1:0]] <= wdata;
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin  <= '0;
      rgray <= '0;
    end else begin
      rbin  <= rbin_nx;
      rgray <= to_gray(rbin_nx);
    end
  end

  pdist_sync #(.W(PTR_W)) u_rptr_sync (
    .clk(wclk), .rst_n(wrst_n), .d(rgray), .q(rgray_at_w)
  );
  pdist_sync #(.W(PTR_W)) u_wptr_sync (
    .clk(rclk), .rst_n(rrst_n), .d(wgray), .q(wgray_at_r)
  );

  assign full  = (wgray == {~rgray_at_w[PTR_W-1:PTR_W-2], rgray_at_w[PTR_W-3:0]});
  assign empty = (rgray == wgray_at_r);
  assign rdata = mem[rbin[AW-1:0]];

  // Occupancy as seen from each side never exceeds the depth
  logic [PTR_W-1:0] wlevel, rlevel;
  assign wlevel = wbin - to_bin(rgray_at_w);
  assign rlevel = to_bin(wgray_at_r) - rbin;

  p_no_overflow_r3: assert property (@(posedge wclk) disable iff (!wrst_n)
    wlevel <= PTR_W'(DEPTH));
  p_no_underflow_r10: assert property (@(posedge rclk) disable iff (!rrst_n)
    rlevel <= PTR_W'(DEPTH));
  p_wgray_step_r10: assert property (@(posedge wclk) disable iff (!wrst_n)
    $countones(wgray ^ $past(wgray)) <= 1);
  p_rgray_step_r10: assert property (@(posedge rclk) disable iff (!rrst_n)
    $countones(rgray ^ $past(rgray)) <= 1);
endmodule

// File: rtl/pdist_bank.sv
`timescale 1ns/1ps
module pdist_bank #(
  parameter int NPARAM = 32,
  parameter int PW     = 14,
  parameter int CMD_W  = 8,
  localparam int IDX_W = $clog2(NPARAM)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pop,
  input  logic [CMD_W-1:0]     cmd,
  input  logic [PW-1:0]        value,
  output logic [NPARAM*PW-1:0] params,
  output logic                 upd_valid,
  output logic [IDX_W-1:0]     upd_idx,
  output logic                 cmd_err
);
  localparam logic [CMD_W-1:0] LIMIT = CMD_W'(NPARAM);

  logic in_range, hit;
  assign in_range = (cmd < LIMIT);
  assign hit      = pop && in_range;

  for (genvar g = 0; g < NPARAM; g++) begin : g_reg
    logic [PW-1:0] r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           r <= '0;
      else if (hit && cmd == CMD_W'(g))     r <= value;
    end
    assign params[g*PW +: PW] = r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upd_valid <= 1'b0;
      upd_idx   <= '0;
      cmd_err   <= 1'b0;
    end else begin
      upd_valid <= hit;
      if (hit)              upd_idx <= cmd[IDX_W-1:0];
      if (pop && !in_range) cmd_err <= 1'b1;
    end
  end

  p_quiet_bank_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |-> $stable(params));
  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |=> cmd_err);
  p_strobe_from_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> $past(pop));
endmodule

// File: rtl/param_xdomain_bank.sv
`timescale 1ns/1ps
module param_xdomain_bank
  import pdist_pkg::*;
#(
  parameter logic [7:0] MODULE_ID = 8'h2A,
  parameter int NPARAM  = 32,
  parameter int PW      = 14,
  parameter int FIFO_AW = 4,
  localparam int IDX_W  = $clog2(NPARAM)
) (
  input  logic                 s_clk,
  input  logic                 s_rst_n,
  input  logic                 s_valid,
  output logic                 s_ready,
  input  logic [63:0]          s_data,
  input  logic                 f_clk,
  input  logic                 f_rst_n,
  output logic [NPARAM*PW-1:0] param_o,
  output logic                 upd_valid,
  output logic [IDX_W-1:0]     upd_idx,
  output logic                 cmd_err
);
  localparam int EW = CMD_W + PW;

  pdist_word_t   w;
  logic          match, full, empty;
  logic [EW-1:0] entry_in, entry_out;
  logic          unused_payload;

  assign w              = s_data;
  assign match          = (w.module_id == MODULE_ID);
  assign entry_in       = {w.cmd, w.payload[PW-1:0]};
  assign unused_payload = ^w.payload[PAY_W-1:PW];
  assign s_ready        = !full;

  pdist_afifo #(.DW(EW), .AW(FIFO_AW)) u_fifo (
    .wclk  (s_clk),
    .wrst_n(s_rst_n),
    .wr_en (s_valid && match),
    .wdata (entry_in),
    .full  (full),
    .rclk  (f_clk),
    .rrst_n(f_rst_n),
    .rd_en (!empty),
    .rdata (entry_out),
    .empty (empty)
  );

  pdist_bank #(.NPARAM(NPARAM), .PW(PW), .CMD_W(CMD_W)) u_bank (
    .clk      (f_clk),
    .rst_n    (f_rst_n),
    .pop      (!empty),
    .cmd      (entry_out[EW-1:PW]),
    .value    (entry_out[PW-1:0]),
    .params   (param_o),
    .upd_valid(upd_valid),
    .upd_idx  (upd_idx),
    .cmd_err  (cmd_err)
  );

  p_hold_stalled_r4: assert property (@(posedge s_clk) disable iff (!s_rst_n)
    (s_valid && !s_ready) |=> (s_valid && $stable(s_data)));
endmodule

// File: tb/tb_param_xdomain_bank.sv
`timescale 1ns/1ps
module tb_param_xdomain_bank;
  localparam logic [7:0] MOD = 8'h2A;
  localparam int NP = 32;
  localparam int PW = 14;

  logic s_clk = 0, f_clk = 0, f_run = 1;
  logic s_rst_n = 0, f_rst_n = 0;
  logic s_valid = 0;
  logic [63:0] s_data = '0;
  logic s_ready, upd_valid, cmd_err;
  logic [NP*PW-1:0] param_o;
  logic [4:0] upd_idx;

  int checks = 0, errors = 0;
  logic [18:0] exp_q[$];
  logic [PW-1:0] shadow [NP];
  bit err_expected = 0;

  always #40 s_clk = ~s_clk;
  always begin #10; if (f_run || f_clk) f_clk = ~f_clk; end

  param_xdomain_bank #(.MODULE_ID(MOD)) dut (
    .s_clk(s_clk), .s_rst_n(s_rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .f_clk(f_clk), .f_rst_n(f_rst_n), .param_o(param_o),
    .upd_valid(upd_valid), .upd_idx(upd_idx), .cmd_err(cmd_err)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(input logic [7:0] m, input logic [7:0] c, input logic [13:0] v);
    logic [33:0] junk;
    junk = 34'({$urandom(), $urandom()});
    return {m, c, junk, v};
  endfunction

  function automatic logic [PW-1:0] slot(input int i);
    return param_o[i*PW +: PW];
  endfunction

  task automatic send(input logic [63:0] wd);
    @(negedge s_clk);
    s_valid = 1;
    s_data  = wd;
    while (!s_ready) @(negedge s_clk);
    @(posedge s_clk);
    if (wd[63:56] == MOD) begin
      if (wd[55:48] < 8'd32) begin
        exp_q.push_back({wd[52:48], wd[13:0]});
        shadow[wd[52:48]] = wd[13:0];
      end else err_expected = 1;
    end
    @(negedge s_clk);
    s_valid = 0;
  endtask

  task automatic drain();
    repeat (10) @(negedge s_clk);
    chk(exp_q.size() == 0, "R5 all accepted updates delivered", exp_q.size(), 0);
  endtask

  task automatic cmp_all(input string req);
    for (int i = 0; i < NP; i++)
      chk(slot(i) == shadow[i], req, slot(i), shadow[i]);
  endtask

  // Strobe monitor: order, index and value alignment
  always @(negedge f_clk) begin
    if (f_rst_n && upd_valid) begin
      if (exp_q.size() == 0) chk(0, "R8 unexpected strobe", upd_idx, 0);
      else begin
        logic [18:0] e;
        e = exp_q.pop_front();
        chk(upd_idx == e[18:14], "R5 update order index", upd_idx, e[18:14]);
        chk(slot(int'(e[18:14])) == e[13:0], "R8 value visible with strobe",
            slot(int'(e[18:14])), e[13:0]);
      end
    end
  end

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < NP; i++) shadow[i] = '0;
    repeat (3) @(negedge s_clk);
    s_rst_n = 1; f_rst_n = 1;
    repeat (2) @(negedge s_clk);
    // R9 reset state
    chk(s_ready == 1, "R9 ready after reset", s_ready, 1);
    chk(upd_valid == 0, "R9 no strobe after reset", upd_valid, 0);
    chk(cmd_err == 0, "R9 error clear after reset", cmd_err, 0);
    chk(param_o == '0, "R9 registers zero", 0, 0);

    // R1/R6: boundary indices and values; junk payload bits above 13
    send(mk(MOD, 8'd0, 14'h3FFF));
    send(mk(MOD, 8'd31, 14'h1555));
    send(mk(MOD, 8'd5, 14'h00AB));
    drain();
    chk(slot(0) == 14'h3FFF, "R1 index 0 full-scale value", slot(0), 14'h3FFF);
    chk(slot(31) == 14'h1555, "R6 index 31 write", slot(31), 14'h1555);
    chk(cmd_err == 0, "R7 no error for valid codes", cmd_err, 0);
    cmp_all("R6 other registers unchanged");

    // R2: foreign module words dropped
    send(mk(MOD + 8'd1, 8'd5, 14'h1111));
    send(mk(8'h00, 8'd0, 14'h0001));
    drain();
    chk(slot(5) == 14'h00AB, "R2 foreign word dropped", slot(5), 14'h00AB);
    chk(slot(0) == 14'h3FFF, "R2 foreign word dropped idx0", slot(0), 14'h3FFF);

    // R7: out-of-range codes ignored, sticky error
    send(mk(MOD, 8'd32, 14'h2222));
    send(mk(MOD, 8'd255, 14'h0F0F));
    drain();
    chk(cmd_err == 1, "R7 error set by code 32", cmd_err, 1);
    cmp_all("R7 out-of-range code changes nothing");
    send(mk(MOD, 8'd9, 14'h0099));
    drain();
    chk(cmd_err == 1, "R7 error stays set", cmd_err, 1);

    // R3/R10: stall the reader, fill FIFO, then drain across wrap
    f_run = 0;
    repeat (2) @(negedge s_clk);
    for (int i = 0; i < 16; i++) send(mk(MOD, 8'(i), 14'($urandom())));
    chk(s_ready == 0, "R3 ready low when 16 held", s_ready, 0);
    repeat (3) @(negedge s_clk);
    chk(s_ready == 0, "R3 ready stays low while stalled", s_ready, 0);
    f_run = 1;
    drain();
    chk(s_ready == 1, "R3 ready back after drain", s_ready, 1);
    cmp_all("R10 data intact across pointer wrap");

    // Random mix
    for (int n = 0; n < 300; n++) begin
      logic [7:0] m, c;
      m = ($urandom() % 4 == 0) ? (MOD ^ 8'(1 + $urandom() % 255)) : MOD;
      c = ($urandom() % 8 == 0) ? 8'(32 + $urandom() % 224) : 8'($urandom() % 32);
      send(mk(m, c, 14'($urandom())));
      repeat ($urandom() % 3) @(negedge s_clk);
    end
    drain();
    cmp_all("R6 random stream final registers");
    chk(cmd_err == err_expected, "R7 error after random stream", cmd_err, err_expected);

    // R9: joint reset
    @(negedge s_clk);
    s_rst_n = 0; f_rst_n = 0;
    repeat (2) @(negedge s_clk);
    chk(param_o == '0, "R9 registers cleared", 0, 0);
    chk(cmd_err == 0, "R9 error cleared", cmd_err, 0);
    chk(upd_valid == 0, "R9 strobe low in reset", upd_valid, 0);
    s_rst_n = 1; f_rst_n = 1;
    for (int i = 0; i < NP; i++) shadow[i] = '0;
    err_expected = 0;
    repeat (2) @(negedge s_clk);
    chk(s_ready == 1, "R9 FIFO empty after reset", s_ready, 1);
    send(mk(MOD, 8'd7, 14'h0007));
    drain();
    chk(slot(7) == 14'h0007, "R4 write after reset", slot(7), 14'h0007);
    cmp_all("R6 registers after reset write");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule